// File: doc/BRIEF.md
# Three-in-a-row ones detector

This block watches a one-bit serial stream, sampled on every rising clock edge, and flags the cycle in which a third 1 in a row arrives. The flag is a Mealy output, so it depends on the present input bit as well as on the stored state. It rises in the same cycle as that third 1, not one cycle later. After a detection the machine returns to its idle state. Runs therefore do not overlap: a fourth 1 in a row counts as the first 1 of a new run.

The machine has three states held in a two-bit register:
- `ST_IDLE` (00): no 1 seen yet.
- `ST_ONE` (01): one 1 seen.
- `ST_TWO` (10): two 1s in a row seen.

Its transitions are:
- `IDLE→ONE`, `ONE→TWO` and `TWO→IDLE(hit)` on a 1.
- `ANY→IDLE` on a 0.

The spare code 11 behaves like idle. The present state is brought out on a port. An 8-bit saturating counter of detections is also provided, so the machine can be observed from outside.

Top module: `ones_run_detector`

## Requirements
- R1: While `rst` is high, `hit_out` is 0 whatever the input and state. After a clock edge with `rst` high, `run_state` is 00 and `hit_count` is 0.
- R2: From any state, an input of 0 moves `run_state` to 00 at the next edge, and `hit_out` is 0 in that cycle.
- R3: From state 00 (`ST_IDLE`), an input of 1 moves `run_state` to 01 (`ST_ONE`), and `hit_out` is 0.
- R4: From state 01 (`ST_ONE`), an input of 1 moves `run_state` to 10 (`ST_TWO`), and `hit_out` is 0.
- R5: In state 10 (`ST_TWO`) with input 1, `hit_out` is 1 in that same cycle and `run_state` becomes 00. No other condition raises `hit_out`.
- R6: Detections do not overlap. A run of n consecutive 1s yields floor(n/3) detections, so a run of six 1s gives exactly two.
- R7: `hit_count` increases by one after each cycle in which `hit_out` is 1, and is unchanged otherwise.
- R8: `hit_count` saturates at 255 and stays there on further detections until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial input bit |
| hit_out | output | 1 | Mealy detect flag, high on the third consecutive 1 |
| run_state | output | 2 | Present state code (00, 01, 10) |
| hit_count | output | 8 | Saturating count of detections |

## Verification
Isolated runs of 1s of each length from one to seven, each closed by a 0, separate a correct non-overlapping machine from two kinds of faulty one. One fires again on the fourth 1. The other fires one cycle late, as a Moore machine would. A zero inserted after each reachable state shows whether the return to idle is honoured from every state. A pseudo-random stream, checked cycle by cycle against a reference model, exercises mixed transitions. A long series of triples drives the counter through its saturation point. Asserting reset while the machine sits in `ST_TWO` with a 1 at the input shows that reset overrides the pending detection.

// File: rtl/run_det_pkg.sv
package run_det_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ONE   = 2'b01,
        ST_TWO   = 2'b10,
        ST_SPARE = 2'b11
    } run_state_t;

endpackage

// File: rtl/run_det_next.sv
module run_det_next
    import run_det_pkg::*;
(
    input  run_state_t cur_state,
    input  logic       rst,
    input  logic       bit_in,
    output run_state_t nxt_state,
    output logic       hit
);

    // next-state process
    always_comb begin
        nxt_state = ST_IDLE;
        if (!rst) begin
            unique case (cur_state)
                ST_IDLE:  nxt_state = bit_in ? ST_ONE : ST_IDLE;
                ST_ONE:   nxt_state = bit_in ? ST_TWO : ST_IDLE;
                ST_TWO:   nxt_state = ST_IDLE;
                ST_SPARE: nxt_state = bit_in ? ST_ONE : ST_IDLE;
                default:  nxt_state = ST_IDLE;
            endcase
        end
    end

    // output process (Mealy)
    always_comb begin
        hit = 1'b0;
        if (!rst) begin
            unique case (cur_state)
                ST_TWO:  hit = bit_in;
                default: hit = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/run_det_state_reg.sv
module run_det_state_reg
    import run_det_pkg::*;
(
    input  logic       clk,
    input  run_state_t nxt_state,
    output run_state_t cur_state
);

    always_ff @(posedge clk) begin
        cur_state <= nxt_state;
    end

endmodule

// File: rtl/run_det_sat_count.sv
module run_det_sat_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] value
);

    localparam logic [W-1:0] MAX_VAL = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)
            value <= '0;
        else if (inc && value != MAX_VAL)
            value <= value + 1'b1;
    end

endmodule

// File: rtl/ones_run_detector.sv
module ones_run_detector #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_in,
    output logic             hit_out,
    output logic [1:0]       run_state,
    output logic [CNT_W-1:0] hit_count
);

    import run_det_pkg::*;

    run_state_t cur_state;
    run_state_t nxt_state;
    logic       hit;

    run_det_next u_next (
        .cur_state (cur_state),
        .rst       (rst),
        .bit_in    (bit_in),
        .nxt_state (nxt_state),
        .hit       (hit)
    );

    run_det_state_reg u_sreg (
        .clk       (clk),
        .nxt_state (nxt_state),
        .cur_state (cur_state)
    );

    run_det_sat_count #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (hit),
        .value (hit_count)
    );

    assign hit_out   = hit;
    assign run_state = cur_state;

endmodule

// File: rtl/ones_run_detector_chk.sv
module ones_run_detector_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             bit_in,
    input logic             hit_out,
    input logic [1:0]       run_state,
    input logic [CNT_W-1:0] hit_count
);

    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    a_r1_no_hit_in_reset: assert property (@(posedge clk)
        rst |-> !hit_out);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (run_state == 2'b00 && hit_count == '0));

    a_r2_zero_idles: assert property (@(posedge clk) disable iff (rst)
        !bit_in |=> run_state == 2'b00);

    a_r3_idle_to_one: assert property (@(posedge clk) disable iff (rst)
        (run_state == 2'b00 && bit_in) |=> run_state == 2'b01);

    a_r4_one_to_two: assert property (@(posedge clk) disable iff (rst)
        (run_state == 2'b01 && bit_in) |=> run_state == 2'b10);

    a_r5_hit_returns_idle: assert property (@(posedge clk) disable iff (rst)
        hit_out |=> run_state == 2'b00);

    a_r7_count_steps: assert property (@(posedge clk) disable iff (rst)
        (hit_out && hit_count != CMAX) |=> hit_count == $past(hit_count) + 1'b1);

    a_r7_count_holds: assert property (@(posedge clk) disable iff (rst)
        !hit_out |=> $stable(hit_count));

    a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
        hit_count == CMAX |=> hit_count == CMAX);

endmodule

bind ones_run_detector ones_run_detector_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_in    (bit_in),
    .hit_out   (hit_out),
    .run_state (run_state),
    .hit_count (hit_count)
);

// File: tb/sim_ones_run_detector.sv
`timescale 1ns/1ps
module sim_ones_run_detector;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_in = 1'b0;
    logic       hit_out;
    logic [1:0] run_state;
    logic [7:0] hit_count;

    int n_chk  = 0;
    int n_fail = 0;

    logic [1:0] ms = 2'b00;
    int         mc = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    ones_run_detector u0 (
        .clk(clk), .rst(rst), .bit_in(bit_in),
        .hit_out(hit_out), .run_state(run_state), .hit_count(hit_count)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one cycle: drive bit, compare against model, advance model
    task automatic step(input logic b, input string req, output logic hit_seen);
        logic exp_hit;
        @(negedge clk);
        check({req, " state"}, run_state, ms);
        check({req, " count R7"}, hit_count, mc);
        bit_in = b;
        #1;
        exp_hit = (ms == 2'b10) && b;
        check({req, " hit"}, hit_out, exp_hit);
        hit_seen = hit_out;
        if (!b)              ms = 2'b00;
        else if (ms == 2'b00) ms = 2'b01;
        else if (ms == 2'b01) ms = 2'b10;
        else                 ms = 2'b00;
        if (exp_hit && mc < 255) mc++;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; bit_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 hit in reset", hit_out, 0);
        check("R1 state after reset", run_state, 0);
        check("R1 count after reset", hit_count, 0);
        bit_in = 1'b0;
        rst = 1'b0;
        ms = 2'b00; mc = 0;
    endtask

    task automatic t_runs();
        logic h;
        for (int len = 1; len <= 7; len++) begin
            int hits = 0;
            for (int i = 0; i < len; i++) begin
                step(1'b1, "R3 R4 R5 run", h);
                if (h) hits++;
            end
            step(1'b0, "R2 run end", h);
            check("R6 hits per run", hits, len / 3);
        end
    endtask

    task automatic t_six();
        logic h;
        int hits = 0;
        int pos4 = 0;
        for (int i = 1; i <= 6; i++) begin
            step(1'b1, "R6 six", h);
            if (h) hits++;
            if (i == 4) pos4 = h;
            if (i == 3) check("R5 hit on third 1", h, 1);
        end
        step(1'b0, "R6 six end", h);
        check("R6 fourth 1 no hit", pos4, 0);
        check("R6 six ones two hits", hits, 2);
    endtask

    task automatic t_zero_each();
        logic h;
        step(1'b0, "R2 zero from idle", h);
        step(1'b1, "R3 to one", h);
        step(1'b0, "R2 zero from one", h);
        step(1'b1, "R3 to one", h);
        step(1'b1, "R4 to two", h);
        step(1'b0, "R2 zero from two", h);
        step(1'b0, "R2 idle check", h);
    endtask

    task automatic t_random();
        logic h;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[3], "R5 random", h);
        end
        step(1'b0, "R2 random end", h);
    endtask

    task automatic t_reset_in_two();
        @(negedge clk);
        bit_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R4 reached two", run_state, 2);
        rst = 1'b1;
        #1;
        check("R1 reset masks hit", hit_out, 0);
        @(negedge clk);
        check("R1 reset state", run_state, 0);
        check("R1 reset count", hit_count, 0);
        rst = 1'b0; bit_in = 1'b0;
        ms = 2'b00; mc = 0;
    endtask

    task automatic t_saturate();
        logic h;
        for (int g = 0; g < 258; g++) begin
            step(1'b1, "R8 sat", h);
            step(1'b1, "R8 sat", h);
            step(1'b1, "R8 sat", h);
        end
        step(1'b0, "R8 sat end", h);
        check("R8 count saturated", hit_count, 255);
    endtask

    initial begin
        #(200000 * 8);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_runs();
        t_six();
        t_zero_each();
        t_random();
        t_reset_in_two();
        t_saturate();
        t_reset();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule